// File: doc/BRIEF.md
# Data/Strobe Character Transmitter

This block turns a stream of bytes into characters on a two-wire data/strobe serial line. Every byte goes out as a ten-bit data character. Flow-control tokens and idle fill go out as four-bit control characters. Only one bit is sent on each clock cycle in which the enable input is high, so a faster or slower line rate comes from how often the enable is asserted.

Sending is limited by credit. Each time the local receiver reports an incoming flow-control token, the credit grows by eight data characters. Each data character that is sent uses one unit of credit. A request from the local side to send a flow-control token is queued, and queued tokens go out before any data. When there is neither a token nor a byte that may be sent, the line carries NULL, which is an escape code followed at once by a flow-control code.

Top module: `ds_char_tx`

## Requirements
- R1: While `rst_n` is low, and after reset until the first enabled tick, `d_out` and `s_out` are 0 and `byte_ready` is 0. Credit and the number of pending tokens both reset to zero.
- R2: A data character is 10 bits, sent in this order: parity, a flag of 0, then the byte least-significant bit first. It starts on the enabled tick in which the byte is accepted.
- R3: A control character is 4 bits, sent in this order: parity, a flag of 1, then a 2-bit code least-significant bit first. The flow-control token is code 00 and escape is code 11.
- R4: At a character boundary with no pending token and no byte that may be sent, the block sends NULL. NULL is escape immediately followed by a flow-control code, 8 bits in all.
- R5: The parity bit makes odd parity over three things: the payload bits of the previous character, the current parity bit, and the current flag. Before the first character, the previous payload counts as even.
- R6: `d_out` carries the bit sent on an enabled tick, starting in the following clock cycle. On each enabled tick exactly one of `d_out` and `s_out` changes: `s_out` toggles when the data bit repeats.
- R7: While `en` is low, no bit is sent, no byte is accepted, and both line outputs hold their values.
- R8: A pulse on `fct_rx` adds 8 to the credit, and the credit saturates at 56. A byte is accepted only while credit is nonzero. Each accepted byte uses one unit of credit.
- R9: A pulse on `fct_req` queues one flow-control token, and the queue saturates at 7. A queued token is sent in preference to data, and `byte_ready` is low while any token is queued.
- R10: `byte_ready` is high only on an enabled tick in which the previous character (or NULL) has been fully sent. A byte is taken when `byte_valid` and `byte_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Bit tick enable; one line bit is sent per cycle when high |
| byte_valid | input | 1 | A byte is offered on `byte_data` |
| byte_data | input | 8 | Byte to send |
| byte_ready | output | 1 | Byte is taken this cycle if `byte_valid` is high |
| fct_req | input | 1 | Pulse: queue one outgoing flow-control token |
| fct_rx | input | 1 | Pulse: a flow-control token was received (+8 credit) |
| d_out | output | 1 | Data wire |
| s_out | output | 1 | Strobe wire |

## Verification
The bench first holds `byte_valid` high with no credit. A design that ignores credit would accept bytes and replace the NULL fill with data characters. It then sends more `fct_rx` pulses than the cap allows, and more `fct_req` pulses than the queue holds, while bytes are waiting. A design that did not saturate, or that let data jump ahead of tokens, would then send a different number of characters, or send them in a different order, than the reference model expects. An `fct_rx` pulse in the same cycle as a byte acceptance tests the order in which credit is added and used. The escape-then-FCT pair inside NULL, followed by data, exposes parity carried over the wrong payload, which shows up as a flipped parity bit on the wire. Irregular enable patterns catch strobe toggling on non-enabled cycles, and bytes accepted in the middle of a character.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;

    localparam int CHAR_BITS = 10;

    typedef logic [1:0] ctl_code_t;
    localparam ctl_code_t CODE_FCT = 2'b00;
    localparam ctl_code_t CODE_ESC = 2'b11;

    // Serializer state: remaining bits (bit 0 goes next), bits left, running payload parity
    typedef struct packed {
        logic [CHAR_BITS-1:0] sh;
        logic [3:0]           cnt;
        logic                 par;
    } frm_state_t;

    // Parity with flag 0: odd over prev payload + P + flag -> P = ~prev
    function automatic logic [CHAR_BITS-1:0] pack_data(input logic [7:0] b, input logic prev);
        return {b, 1'b0, ~prev};
    endfunction

    // Parity with flag 1 -> P = prev
    function automatic logic [CHAR_BITS-1:0] pack_ctrl(input ctl_code_t code, input logic prev);
        return {6'b000000, code, 1'b1, prev};
    endfunction

    // Escape then flow-control; escape payload parity is even, so the second P is 0
    function automatic logic [CHAR_BITS-1:0] pack_null(input logic prev);
        return {2'b00, CODE_FCT, 1'b1, 1'b0, CODE_ESC, 1'b1, prev};
    endfunction

endpackage

// File: rtl/ds_tx_satcnt.sv
module ds_tx_satcnt #(
    parameter int MAX  = 56,
    parameter int STEP = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic nz
);
    localparam int W = $clog2(MAX + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        int tmp;
        tmp = int'(cnt_q) - (dec ? 1 : 0);
        if (inc) begin
            tmp = (tmp + STEP > MAX) ? MAX : tmp + STEP;
        end
        cnt_d = W'(tmp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign nz = (cnt_q != '0);

    p_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= MAX)
        else $error("counter above cap");

    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> cnt_q != '0)
        else $error("decrement of empty counter");

    p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && int'(cnt_q) + STEP <= MAX) |=> int'(cnt_q) == int'($past(cnt_q)) + STEP)
        else $error("refill step wrong");

endmodule

// File: rtl/ds_tx_framer.sv
module ds_tx_framer
    import ds_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       credit_ok,
    input  logic       fct_pending,
    output logic       byte_ready,
    output logic       take_data,
    output logic       take_fct,
    output logic       bit_out
);
    frm_state_t st_d, st_q;
    logic       at_edge;

    assign at_edge    = (st_q.cnt == 4'd0);
    assign byte_ready = en && at_edge && !fct_pending && credit_ok;
    assign take_data  = byte_ready && byte_valid;

    always_comb begin
        logic [CHAR_BITS-1:0] vec;
        logic [3:0]           last;
        logic                 npar;
        st_d     = st_q;
        take_fct = 1'b0;
        bit_out  = st_q.sh[0];
        vec      = '0;
        last     = 4'd0;
        npar     = st_q.par;
        if (en) begin
            if (at_edge) begin
                if (fct_pending) begin
                    vec      = pack_ctrl(CODE_FCT, st_q.par);
                    last     = 4'd3;
                    npar     = ^CODE_FCT;
                    take_fct = 1'b1;
                end else if (take_data) begin
                    vec  = pack_data(byte_data, st_q.par);
                    last = 4'd9;
                    npar = ^byte_data;
                end else begin
                    vec  = pack_null(st_q.par);
                    last = 4'd7;
                    npar = ^CODE_FCT;
                end
                bit_out   = vec[0];
                st_d.sh   = {1'b0, vec[CHAR_BITS-1:1]};
                st_d.cnt  = last;
                st_d.par  = npar;
            end else begin
                st_d.sh  = {1'b0, st_q.sh[CHAR_BITS-1:1]};
                st_d.cnt = st_q.cnt - 4'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_data_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_data |=> st_q.cnt == 4'd9)
        else $error("data character length wrong");

    p_fct_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_fct |=> st_q.cnt == 4'd3)
        else $error("control character length wrong");

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q))
        else $error("serializer moved without enable");

endmodule

// File: rtl/ds_tx_lineenc.sv
module ds_tx_lineenc (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bit_in,
    output logic d_out,
    output logic s_out
);
    logic d_d, d_q, s_d, s_q;

    always_comb begin
        d_d = d_q;
        s_d = s_q;
        if (en) begin
            d_d = bit_in;
            s_d = (bit_in == d_q) ? ~s_q : s_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= 1'b0;
            s_q <= 1'b0;
        end else begin
            d_q <= d_d;
            s_q <= s_d;
        end
    end

    assign d_out = d_q;
    assign s_out = s_q;

endmodule

// File: rtl/ds_char_tx.sv
module ds_char_tx #(
    parameter int CREDIT_MAX  = 56,
    parameter int CREDIT_STEP = 8,
    parameter int FCT_QMAX    = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    output logic       byte_ready,
    input  logic       fct_req,
    input  logic       fct_rx,
    output logic       d_out,
    output logic       s_out
);
    logic credit_nz, pend_nz, take_data, take_fct, line_bit;

    ds_tx_satcnt #(.MAX(CREDIT_MAX), .STEP(CREDIT_STEP)) u_credit (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (fct_rx),
        .dec   (take_data),
        .nz    (credit_nz)
    );

    ds_tx_satcnt #(.MAX(FCT_QMAX), .STEP(1)) u_fctq (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (fct_req),
        .dec   (take_fct),
        .nz    (pend_nz)
    );

    ds_tx_framer u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .credit_ok   (credit_nz),
        .fct_pending (pend_nz),
        .byte_ready  (byte_ready),
        .take_data   (take_data),
        .take_fct    (take_fct),
        .bit_out     (line_bit)
    );

    ds_tx_lineenc u_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .bit_in (line_bit),
        .d_out  (d_out),
        .s_out  (s_out)
    );

    p_one_wire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ((d_out != $past(d_out)) != (s_out != $past(s_out))))
        else $error("not exactly one wire changed");

    p_line_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(d_out) && $stable(s_out)))
        else $error("line moved without enable");

    p_fct_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> !pend_nz)
        else $error("data offered while token queued");

    p_credit_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_ready) |-> credit_nz)
        else $error("byte taken without credit");

    p_single_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({take_data, take_fct}) <= 1)
        else $error("two characters started at once");

endmodule

// File: tb/tb_ds_char_tx.sv
`timescale 1ns/1ps
module tb_ds_char_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, byte_valid = 1'b0, fct_req = 1'b0, fct_rx = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       byte_ready, d_out, s_out;

    int checks = 0;
    int errors = 0;

    // reference model state
    bit   q[$];
    int   cred = 0, pend = 0, prev_par = 0;
    logic exp_d = 1'b0, exp_s = 1'b0;
    logic [7:0] nb = 8'h3C;

    always #4 clk = ~clk;

    ds_char_tx dut (
        .clk(clk), .rst_n(rst_n), .en(en), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_ready(byte_ready), .fct_req(fct_req),
        .fct_rx(fct_rx), .d_out(d_out), .s_out(s_out)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // R5: parity odd over previous payload ones + P + flag
    task automatic push_ch(input int flag, input int payload, input int nbits);
        int ones;
        int p;
        p = ((prev_par + flag) % 2 == 0) ? 1 : 0;
        q.push_back(bit'(p));
        q.push_back(bit'(flag));
        ones = 0;
        for (int i = 0; i < nbits; i++) begin
            q.push_back(bit'((payload >> i) & 1));
            ones += (payload >> i) & 1;
        end
        prev_par = ones % 2;
    endtask

    task automatic step(input logic e, input logic v, input logic fr, input logic fx);
        logic exp_ready;
        bit   b;
        int   took_d;
        int   took_f;
        en = e; byte_valid = v; byte_data = nb; fct_req = fr; fct_rx = fx;
        #1;
        exp_ready = e && (q.size() == 0) && (pend == 0) && (cred > 0);
        chk(byte_ready, exp_ready, "R8 R9 R10 byte_ready");
        @(posedge clk);
        took_d = 0; took_f = 0;
        if (e) begin
            if (q.size() == 0) begin
                if (pend > 0) begin
                    push_ch(1, 0, 2);          // R3 FCT code 00
                    took_f = 1;
                end else if (v && cred > 0) begin
                    push_ch(0, int'(nb), 8);   // R2 data character
                    took_d = 1;
                end else begin
                    push_ch(1, 3, 2);          // R4 escape code 11
                    push_ch(1, 0, 2);          // then FCT
                end
            end
            b = q.pop_front();
            if (logic'(b) == exp_d) exp_s = ~exp_s;
            exp_d = logic'(b);
        end
        pend -= took_f;
        if (fr) pend = (pend + 1 > 7) ? 7 : pend + 1;
        cred -= took_d;
        if (fx) cred = (cred + 8 > 56) ? 56 : cred + 8;
        if (took_d == 1) nb = nb + 8'd7;
        @(negedge clk);
        chk(d_out, exp_d, "R2 R3 R4 R5 R6 R7 d_out");
        chk(s_out, exp_s, "R6 R7 s_out");
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(d_out, 1'b0, "R1 reset d_out");
        chk(s_out, 1'b0, "R1 reset s_out");
        chk(byte_ready, 1'b0, "R1 reset byte_ready");
        rst_n = 1'b1;
        @(negedge clk);
        chk(d_out, 1'b0, "R1 after reset d_out");
        chk(s_out, 1'b0, "R1 after reset s_out");

        // R4/R8: no credit, byte offered, only NULL goes out
        for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
        // R7: enable low holds everything
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
        // R8: one credit grant, eight bytes then stall
        step(1'b0, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 140; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
        // R9: token requests beat data, queue saturation at 7
        step(1'b1, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 120; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
        // R8: credit saturation at 56, grant coincident with sends
        for (int i = 0; i < 9; i++) step(1'b1, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 700; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
        // mixed enables, valid, requests and grants
        for (int i = 0; i < 3000; i++) begin
            step(logic'(($urandom % 4) != 0), logic'(($urandom % 3) != 0),
                 logic'(($urandom % 29) == 0), logic'(($urandom % 41) == 0));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule